// File: doc/BRIEF.md
# Request-Triggered Serial Result Readout

This block is the host-facing readout stage of a sensor front end. A host pulls an active-low request line low. Once the low level has lasted a minimum number of microsecond ticks, the block asks an external acquisition engine for one measurement through a start/done handshake. When the engine reports completion, the block latches the result and pulls its active-low data-ready output low. It then waits for the host to clock the result out over a host-driven serial clock: high byte first, then low byte, each MSB first.

If the host is still holding the request low when the measurement finishes, the block does not offer data. It raises a setup-mode flag instead, and keeps it until the request is released. The serial data and data-ready outputs are modelled as pin values with separate output enables. Both enables are off whenever no result is waiting, so several such blocks can share the clock, data and ready wires, with one request line each.

A mode input selects the idle level of the serial clock. With an idle-low clock, data changes on the rising edge. With an idle-high clock, data changes on the falling edge. The host samples on the opposite edge in both cases. The serial clock and the request are synchronized into the system clock before use.

Top module: `rdo_top`

## Requirements
- R1: After reset, acq_start, setup_flag, drdy_oe and sdo_oe are all 0.
- R2: A request (req_n low) that ends before REQ_MIN_TICKS tick_us pulses have been seen while it is low produces no acq_start and leaves drdy_oe at 0.
- R3: A request held low for at least REQ_MIN_TICKS ticks produces exactly one acq_start pulse, one system clock wide, per low period.
- R4: When acq_done arrives while the request is released (req_n high), the block latches acq_data. It then drives drdy_n_o = 0 with drdy_oe = 1, and sets sdo_oe = 1.
- R5: When acq_done arrives while req_n is still low, setup_flag goes to 1 and drdy_oe and sdo_oe stay 0. setup_flag returns to 0 after req_n goes high.
- R6: With sck_idle_high = 0, each rising SCK edge launches the next bit on sdo_o. The order is bit 15 down to bit 0: high byte, then low byte, each MSB first.
- R7: With sck_idle_high = 1, each falling SCK edge launches the next bit, in the same order as R6.
- R8: After the sampling edge of the last bit, drdy_oe and sdo_oe return to 0 and the block can accept a new request.
- R9: Changes on acq_data after acq_done do not alter the bits shifted out.
- R10: SCK edges that occur while no result is waiting (idle or during acquisition) are ignored: the next transfer still starts with bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse per microsecond, used for request width |
| req_n | input | 1 | Active-low request from host (asynchronous) |
| sck | input | 1 | Host serial clock (asynchronous) |
| sck_idle_high | input | 1 | 1: SCK idles high, data changes on falling edge; 0: idles low, changes on rising edge |
| acq_start | output | 1 | One-cycle start pulse to the acquisition engine |
| acq_done | input | 1 | One-cycle completion pulse from the acquisition engine |
| acq_data | input | 16 | Measurement result, valid with acq_done |
| drdy_n_o | output | 1 | Data-ready pin value (active low) |
| drdy_oe | output | 1 | Data-ready output enable; 0 means floating |
| sdo_o | output | 1 | Serial data pin value |
| sdo_oe | output | 1 | Serial data output enable; 0 means floating |
| setup_flag | output | 1 | High while the block sits in setup mode |

## Verification
The request filter is tried with a short low pulse and with a long one. This separates a working width check from a filter that passes every pulse or that fires more than once per low period. Readouts are run in both clock polarities with different data words whose bytes differ. A swapped launch edge, a reversed bit order or a byte swap would each show up as wrong sampled bits. SCK is toggled while idle and during acquisition, and acq_data is changed just after acq_done. This shows whether the bit counter and the result register are protected. A final acquisition completes while the request is still held low, which tells setup entry apart from a normal readout.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACQ   = 2'd1,
      ST_READY = 2'd2,
      ST_SETUP = 2'd3
   } rdo_state_e;
endpackage

// File: rtl/rdo_sync.sv
module rdo_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rdo_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rdo_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rdo_req_filter.sv
module rdo_req_filter #(
   parameter int MIN_TICKS = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic req_low,
   output logic valid
);
   localparam int CNT_W = $clog2(MIN_TICKS + 1);

   if (MIN_TICKS < 1) begin : g_bad_min
      $error("rdo_req_filter: MIN_TICKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             fired_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
         valid   <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (!req_low) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
         end else if (tick && !fired_q) begin
            if (cnt_q == CNT_W'(MIN_TICKS - 1)) begin
               fired_q <= 1'b1;
               valid   <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R2: a qualification pulse only follows a low request level
   p_valid_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(req_low));
   // R3: never two qualifications back to back
   p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
endmodule

// File: rtl/rdo_shifter.sv
module rdo_shifter #(
   parameter int RES_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sck_s,
   input  logic             idle_high,
   input  logic             active,
   input  logic [RES_W-1:0] data,
   output logic             sdo,
   output logic             done
);
   localparam int NBYTES = RES_W / BYTE_W;
   localparam int BYI_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam int BIT_W  = $clog2(BYTE_W + 1);
   localparam int IDX_W  = (RES_W > 1) ? $clog2(RES_W) : 1;

   if (RES_W % BYTE_W != 0) begin : g_bad_div
      $error("rdo_shifter: RES_W must be a multiple of BYTE_W");
   end
   if (NBYTES < 2) begin : g_bad_bytes
      $error("rdo_shifter: at least two bytes per result");
   end

   logic             sck_d;
   logic             rise, fall, launch, sample;
   logic [BYI_W-1:0] byte_idx;
   logic [BIT_W-1:0] bit_idx;
   logic [31:0]      launched;
   logic [31:0]      pos;
   logic             last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign rise = sck_s & ~sck_d;
   assign fall = ~sck_s & sck_d;

   // polarity variant: the launch edge is the one leaving the idle level
   always_comb begin
      if (idle_high) begin
         launch = fall;
         sample = rise;
      end else begin
         launch = rise;
         sample = fall;
      end
   end

   assign last_bit = (byte_idx == BYI_W'(NBYTES - 1)) &&
                     (bit_idx == BIT_W'(BYTE_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_idx <= '0;
         bit_idx  <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            byte_idx <= '0;
            bit_idx  <= '0;
         end else if (launch && !last_bit) begin
            if (bit_idx == BIT_W'(BYTE_W)) begin
               byte_idx <= byte_idx + 1'b1;
               bit_idx  <= BIT_W'(1);
            end else begin
               bit_idx <= bit_idx + 1'b1;
            end
         end else if (sample && last_bit) begin
            done <= 1'b1;
         end
      end
   end

   always_comb begin
      launched = 32'(byte_idx) * BYTE_W + 32'(bit_idx);
      if (launched == 32'd0) pos = RES_W - 1;
      else                   pos = RES_W - launched;
      sdo = data[pos[IDX_W-1:0]];
   end

   // R8: never more bits launched than the result holds
   p_bits_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      launched <= RES_W);
   // R6: a launch at a full byte starts the next byte at its first bit
   p_byte_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && launch && !last_bit && bit_idx == BIT_W'(BYTE_W)) |=>
      (bit_idx == BIT_W'(1) || !active));
   // R10: counters stay cleared while no result waits
   p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && $past(!active)) |-> (launched == 32'd0));
endmodule

// File: rtl/rdo_top.sv
module rdo_top #(
   parameter int RES_W         = 16,
   parameter int BYTE_W        = 8,
   parameter int REQ_MIN_TICKS = 30,
   parameter int SYNC_STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_us,
   input  logic             req_n,
   input  logic             sck,
   input  logic             sck_idle_high,
   output logic             acq_start,
   input  logic             acq_done,
   input  logic [RES_W-1:0] acq_data,
   output logic             drdy_n_o,
   output logic             drdy_oe,
   output logic             sdo_o,
   output logic             sdo_oe,
   output logic             setup_flag
);
   import rdo_pkg::*;

   if (RES_W != 2 * BYTE_W) begin : g_bad_frame
      $error("rdo_top: result framing expects exactly two bytes");
   end

   logic             req_n_s, sck_s, req_low, req_valid, shift_done, sdo_raw;
   logic [RES_W-1:0] res_q;
   rdo_state_e       state, state_nx;

   rdo_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_n), .q(req_n_s));

   rdo_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s));

   assign req_low = ~req_n_s;

   rdo_req_filter #(.MIN_TICKS(REQ_MIN_TICKS)) u_filter (
      .clk(clk), .rst_n(rst_n), .tick(tick_us),
      .req_low(req_low), .valid(req_valid));

   rdo_shifter #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .idle_high(sck_idle_high),
      .active(state == ST_READY), .data(res_q), .sdo(sdo_raw),
      .done(shift_done));

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (req_valid) state_nx = ST_ACQ;
         ST_ACQ:   if (acq_done)  state_nx = req_low ? ST_SETUP : ST_READY;
         ST_READY: if (shift_done) state_nx = ST_IDLE;
         ST_SETUP: if (!req_low)  state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         acq_start <= 1'b0;
         res_q     <= '0;
      end else begin
         state     <= state_nx;
         acq_start <= (state == ST_IDLE) && req_valid;
         if (state == ST_ACQ && acq_done && !req_low) res_q <= acq_data;
      end
   end

   assign drdy_oe    = (state == ST_READY);
   assign drdy_n_o   = ~drdy_oe;
   assign sdo_oe     = (state == ST_READY);
   assign sdo_o      = sdo_oe ? sdo_raw : 1'b0;
   assign setup_flag = (state == ST_SETUP);

   // R3: start is a single-cycle pulse
   p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acq_start |=> !acq_start);
   // R3: start only after a qualified request
   p_start_from_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acq_start |-> $past(req_valid));
   // R9: latched result is held through the whole transfer
   p_result_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (drdy_oe && $past(drdy_oe)) |-> $stable(res_q));
   // R5: setup mode never offers data
   p_setup_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
      setup_flag |-> (!drdy_oe && !sdo_oe));
   // R8: ready is withdrawn only at the end of the last bit
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drdy_oe) |-> $past(shift_done));
endmodule

// File: tb/sim_rdo_top.sv
module sim_rdo_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_us = 1'b0;
   logic        req_n = 1'b1;
   logic        sck = 1'b0;
   logic        sck_idle_high = 1'b0;
   logic        acq_done = 1'b0;
   logic [15:0] acq_data = 16'h0000;
   logic        acq_start, drdy_n_o, drdy_oe, sdo_o, sdo_oe, setup_flag;

   int checks = 0;
   int failures = 0;
   int start_cnt = 0;
   int wide_start = 0;
   int cyc_cnt = 0;
   int tdiv = 0;
   logic start_prev = 1'b0;

   rdo_top u0 (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .req_n(req_n), .sck(sck),
      .sck_idle_high(sck_idle_high), .acq_start(acq_start),
      .acq_done(acq_done), .acq_data(acq_data), .drdy_n_o(drdy_n_o),
      .drdy_oe(drdy_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
      .setup_flag(setup_flag));

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
      tick_us <= (tdiv == 3);
   end

   always @(posedge clk) begin
      cyc_cnt <= cyc_cnt + 1;
      start_prev <= acq_start;
      if (acq_start) start_cnt <= start_cnt + 1;
      if (acq_start && start_prev) wide_start <= wide_start + 1;
      if (cyc_cnt > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      wait_cyc(3);
      check("R1 acq_start", 32'(acq_start), 0);
      check("R1 setup_flag", 32'(setup_flag), 0);
      check("R1 drdy_oe", 32'(drdy_oe), 0);
      check("R1 sdo_oe", 32'(sdo_oe), 0);
   endtask

   task automatic t_short_req();
      int s0 = start_cnt;
      req_n = 1'b0;
      wait_cyc(80);
      req_n = 1'b1;
      wait_cyc(40);
      check("R2 no start on short request", 32'(start_cnt - s0), 0);
      check("R2 drdy stays floating", 32'(drdy_oe), 0);
   endtask

   task automatic toggle_sck(input int n);
      for (int i = 0; i < n; i++) begin
         sck = ~sck; wait_cyc(20);
         sck = ~sck; wait_cyc(20);
      end
   endtask

   task automatic t_readout(input logic idle_high, input logic [15:0] val);
      int s0 = start_cnt;
      int w0 = wide_start;
      sck_idle_high = idle_high;
      sck = idle_high;
      toggle_sck(3);               // R10: idle edges
      req_n = 1'b0;
      wait_cyc(200);
      req_n = 1'b1;
      wait_cyc(10);
      check("R3 one start per request", 32'(start_cnt - s0), 1);
      check("R3 start one cycle wide", 32'(wide_start - w0), 0);
      toggle_sck(2);               // R10: edges during acquisition
      acq_data = val;
      acq_done = 1'b1;
      wait_cyc(1);
      acq_done = 1'b0;
      acq_data = ~val;             // R9: later data must not leak
      wait_cyc(10);
      check("R4 data ready low", 32'({drdy_oe, drdy_n_o, sdo_oe}), 32'b101);
      for (int i = 0; i < 16; i++) begin
         sck = ~idle_high;         // launch edge
         wait_cyc(20);
         check(idle_high ? "R7 bit (falling launch) R9" :
                           "R6 bit (rising launch) R9",
               32'(sdo_o), 32'(val[15-i]));
         sck = idle_high;          // sample edge
         wait_cyc(20);
         if (i == 7) wait_cyc(60); // byte gap
      end
      check("R8 outputs float after last bit", 32'({drdy_oe, sdo_oe}), 0);
   endtask

   task automatic t_setup();
      int s0 = start_cnt;
      req_n = 1'b0;
      wait_cyc(200);
      check("R3 start while held", 32'(start_cnt - s0), 1);
      acq_data = 16'hFFFF;
      acq_done = 1'b1;
      wait_cyc(1);
      acq_done = 1'b0;
      wait_cyc(10);
      check("R5 setup flag set", 32'(setup_flag), 1);
      check("R5 no data ready in setup", 32'({drdy_oe, sdo_oe}), 0);
      req_n = 1'b1;
      wait_cyc(10);
      check("R5 setup flag clears", 32'(setup_flag), 0);
   endtask

   initial begin
      wait_cyc(4);
      rst_n = 1'b1;
      t_reset();
      t_short_req();
      t_readout(1'b0, 16'hA53C);
      t_readout(1'b1, 16'h3C96);
      t_readout(1'b0, 16'h01FE);
      t_setup();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule